// File: doc/BRIEF.md
# Prefixed Effective Address Generator

This unit turns the addressing part of an instruction for an 8-bit core with a 16-bit address space into an operand address. It looks at the upper opcode nibble, which holds the mode field, and at a prefix byte that the fetch logic saw ahead of the opcode. It also takes the two operand bytes that follow the opcode, both index registers, and a flag that marks the operand as a write destination. For each request it returns one of three results: an address, a marker that the operand is an immediate, or an error for a combination that has no meaning.

The prefix can do two things. It can steer every index reference from X to Y. It can also turn the first operand byte into a zero-page location that holds a pointer. The unit then reads that pointer, one byte per read, through a byte-wide synchronous read port. An index may be added to the pointer afterwards. Address forms that need no pointer finish in a single cycle. Requests that arrive while a pointer fetch is still running are dropped.

Top module: `ea_gen`

## Requirements
- R1: With no indirection, mode 011 (opc_upper[2:0]) yields the first operand byte zero-extended. Mode 100 yields {first byte, second byte}, with the first byte as the high half.
- R2: Mode 110 adds the selected index to the zero-extended first byte at 16-bit width, so 0xFF + 0xFF gives 0x01FE. Mode 101 adds the index to the 16-bit operand, and the sum wraps modulo 65536. Mode 111 yields the index alone.
- R3: Prefix 0x90 or 0x91 selects idx_y as the index. Every other prefix value selects idx_x.
- R4: Prefix 0x92 reads a pointer at zero-page address {0x00, first byte}. Modes 011 and 110 use a one-byte pointer. Modes 100 and 101 use a two-byte pointer: the high byte sits at that address and the low byte at the next address modulo 256. Modes 110 and 101 then add the index to the pointer.
- R5: Prefix 0x91 applies both the Y selection and the pointer indirection.
- R6: Mode 010 gives ea_imm=1, ea=0 and no error. If is_dest is 1, mode 010 gives ea_err=1 instead.
- R7: An error is raised when opc_upper[3] is 0, when the mode is 000 or 001, or when an indirection prefix (0x91 or 0x92) is used with mode 010 or 111. An error issues no reads, leaves ea=0, and still pulses done.
- R8: A request accepted in cycle n completes in one of three cycles. Without indirection, done is high in cycle n+1. With a one-byte pointer, done is high in cycle n+3. With a two-byte pointer, done is high in cycle n+5, which is one cycle after the last byte appears on rd_data. Each request gives exactly one done pulse.
- R9: rd_en is high for one cycle per pointer byte, only ever for a zero-page rd_addr. The read data is expected on rd_data in the following cycle.
- R10: A start that arrives while a pointer fetch is in progress is ignored. It affects neither the result nor the number of done pulses.
- R11: While reset is high and afterwards until the first completion, done, ea_imm, ea_err and rd_en are 0 and ea is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; inputs are sampled with it |
| opc_upper | input | 4 | Opcode bits 7:4 (bit 3 = opcode bit 7, bits 2:0 = mode) |
| prefix | input | 8 | Prefix byte seen before the opcode, 0x00 if none |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| is_dest | input | 1 | Operand is the destination |
| rd_en | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte address |
| rd_data | input | 8 | Byte returned the cycle after rd_en |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address, held until next completion |
| ea_imm | output | 1 | Immediate operand marker, pulses with done |
| ea_err | output | 1 | Illegal combination, pulses with done |

## Verification
Directed vectors place an 8-bit offset and index both at 0xFF, which separates a full-width sum from a byte-wide one. A 16-bit sum that overflows shows whether the address wraps. A pointer at zero-page address 0xFF shows whether the second pointer byte wraps inside the zero page. Each prefix is paired with each mode, which separates the index choice from the indirection choice, and the error cases are kept apart from the immediate cases. Random vectors mix modes, prefixes, destination flags and stray prefix values. The per-request latency, the read count and the number of done pulses separate one-byte pointers from two-byte pointers. An extra start issued during a fetch checks that the unit is not disturbed while busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    M_RSV0  = 3'b000,
    M_RSV1  = 3'b001,
    M_IMM   = 3'b010,
    M_ABS8  = 3'b011,
    M_ABS16 = 3'b100,
    M_IX16  = 3'b101,
    M_IX8   = 3'b110,
    M_IX    = 3'b111
  } amode_t;

  localparam logic [7:0] PFX_YSEL = 8'h90;
  localparam logic [7:0] PFX_YIND = 8'h91;
  localparam logic [7:0] PFX_IND  = 8'h92;

  typedef enum logic [2:0] {
    F_IDLE,
    F_WAIT_A,
    F_CAP_A,
    F_WAIT_B,
    F_CAP_B
  } fstate_t;

  typedef struct packed {
    logic bad;
    logic imm;
    logic ind;
    logic wide;
    logic idx;
    logic ysel;
  } adec_t;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] opc_upper,
  input  logic [7:0] prefix,
  input  logic       is_dest,
  output amode_t     mode,
  output adec_t      dec
);

  always_comb begin
    mode     = amode_t'(opc_upper[2:0]);
    dec.ysel = (prefix == PFX_YSEL) || (prefix == PFX_YIND);
    dec.ind  = (prefix == PFX_YIND) || (prefix == PFX_IND);
    dec.imm  = (mode == M_IMM);
    dec.wide = (mode == M_ABS16) || (mode == M_IX16);
    dec.idx  = (mode == M_IX16) || (mode == M_IX8) || (mode == M_IX);
    dec.bad  = !opc_upper[3]
             || (mode == M_RSV0) || (mode == M_RSV1)
             || (dec.ind && (dec.imm || (mode == M_IX)))
             || (is_dest && dec.imm);
  end

endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] index,
  input  logic          use_index,
  output logic [AW-1:0] sum
);

  logic [AW-1:0] ext;

  always_comb begin
    ext = use_index ? AW'(index) : '0;
    sum = base + ext;
  end

endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] zp,
  input  logic          wide,
  input  logic [DW-1:0] rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          ptr_ok,
  output logic [AW-1:0] ptr_val
);

  fstate_t       st;
  logic [DW-1:0] zp_q;
  logic          wide_q;
  logic [DW-1:0] hi_q;
  logic [2*DW-1:0] pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      zp_q    <= '0;
      wide_q  <= 1'b0;
      hi_q    <= '0;
    end else begin
      case (st)
        F_IDLE: begin
          if (go) begin
            rd_en   <= 1'b1;
            rd_addr <= AW'(zp);
            zp_q    <= zp;
            wide_q  <= wide;
            st      <= F_WAIT_A;
          end
        end
        F_WAIT_A: begin
          rd_en <= 1'b0;
          st    <= F_CAP_A;
        end
        F_CAP_A: begin
          if (wide_q) begin
            hi_q    <= rd_data;
            rd_en   <= 1'b1;
            rd_addr <= AW'(DW'(zp_q + 1'b1));
            st      <= F_WAIT_B;
          end else begin
            st <= F_IDLE;
          end
        end
        F_WAIT_B: begin
          rd_en <= 1'b0;
          st    <= F_CAP_B;
        end
        F_CAP_B: st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    pair    = {hi_q, rd_data};
    busy    = (st != F_IDLE);
    ptr_ok  = ((st == F_CAP_A) && !wide_q) || (st == F_CAP_B);
    ptr_val = (st == F_CAP_B) ? AW'(pair) : AW'(rd_data);
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    opc_upper,
  input  logic [7:0]    prefix,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic          is_dest,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          ea_imm,
  output logic          ea_err
);

  amode_t        mode;
  adec_t         dec;
  logic          f_busy;
  logic          ptr_ok;
  logic [AW-1:0] ptr_val;
  logic          accept;
  logic          go;
  logic [DW-1:0] idx_now;
  logic [DW-1:0] idx_q;
  logic          useidx_q;
  logic [AW-1:0] dir_base;
  logic [AW-1:0] add_base;
  logic [DW-1:0] add_idx;
  logic          add_use;
  logic [AW-1:0] sum;
  logic [2*DW-1:0] opnd_pair;

  ea_decode u_dec (
    .opc_upper (opc_upper),
    .prefix    (prefix),
    .is_dest   (is_dest),
    .mode      (mode),
    .dec       (dec)
  );

  ea_ptr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .zp      (opnd_a),
    .wide    (dec.wide),
    .rd_data (rd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .busy    (f_busy),
    .ptr_ok  (ptr_ok),
    .ptr_val (ptr_val)
  );

  always_comb begin
    opnd_pair = {opnd_a, opnd_b};
    case (mode)
      M_ABS8, M_IX8:   dir_base = AW'(opnd_a);
      M_ABS16, M_IX16: dir_base = AW'(opnd_pair);
      default:         dir_base = '0;
    endcase
    idx_now  = dec.ysel ? idx_y : idx_x;
    accept   = start && !f_busy;
    go       = accept && dec.ind && !dec.bad;
    add_base = f_busy ? ptr_val  : dir_base;
    add_idx  = f_busy ? idx_q    : idx_now;
    add_use  = f_busy ? useidx_q : dec.idx;
  end

  ea_index_add #(.AW(AW), .DW(DW)) u_add (
    .base      (add_base),
    .index     (add_idx),
    .use_index (add_use),
    .sum       (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      ea       <= '0;
      ea_imm   <= 1'b0;
      ea_err   <= 1'b0;
      idx_q    <= '0;
      useidx_q <= 1'b0;
    end else begin
      done   <= 1'b0;
      ea_imm <= 1'b0;
      ea_err <= 1'b0;
      if (go) begin
        idx_q    <= idx_now;
        useidx_q <= dec.idx;
      end
      if (accept && (dec.bad || !dec.ind)) begin
        done   <= 1'b1;
        ea_err <= dec.bad;
        ea_imm <= !dec.bad && dec.imm;
        ea     <= (dec.bad || dec.imm) ? '0 : sum;
      end else if (ptr_ok) begin
        done <= 1'b1;
        ea   <= sum;
      end
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic [7:0]    prefix,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          ea_imm,
  input logic          ea_err
);

  a_r7_err_clean: assert property (@(posedge clk) disable iff (rst)
    ea_err |-> (done && ea == '0));

  a_r6_imm_clean: assert property (@(posedge clk) disable iff (rst)
    ea_imm |-> (done && !ea_err && ea == '0));

  a_r9_zero_page: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[AW-1:DW] == '0));

  a_r9_one_cycle_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  a_r8_direct_latency: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && prefix != 8'h91 && prefix != 8'h92) |=> done);

  a_r10_busy_no_err: assert property (@(posedge clk) disable iff (rst)
    busy |=> !ea_err);

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (f_busy),
  .prefix  (prefix),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .done    (done),
  .ea      (ea),
  .ea_imm  (ea_imm),
  .ea_err  (ea_err)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  opc_upper = '0;
  logic [7:0]  prefix = '0;
  logic [7:0]  opnd_a = '0;
  logic [7:0]  opnd_b = '0;
  logic [7:0]  idx_x = '0;
  logic [7:0]  idx_y = '0;
  logic        is_dest = 1'b0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic [15:0] ea;
  logic        ea_imm;
  logic        ea_err;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;

  always #2 clk = ~clk;

  ea_gen u0 (
    .clk(clk), .rst(rst), .start(start), .opc_upper(opc_upper),
    .prefix(prefix), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .idx_x(idx_x), .idx_y(idx_y), .is_dest(is_dest),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .ea(ea), .ea_imm(ea_imm), .ea_err(ea_err)
  );

  function automatic logic [7:0] mb(input logic [7:0] a);
    logic [15:0] t;
    t = {8'h00, a} * 16'd73 + 16'd41;
    return t[7:0] ^ {a[4:0], a[7:5]};
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mb(rd_addr[7:0]);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_en) begin
      rd_cnt++;
      if (rd_addr[15:8] != 8'h00) begin
        n_chk++;
        n_bad++;
        $display("FAIL R9 read outside zero page: got %0h expected 00xx", rd_addr);
      end
    end
  end

  function automatic void model(input logic [7:0] op, input logic [7:0] pf,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] x,
      input logic [7:0] y, input logic dst, output logic [15:0] e,
      output logic im, output logic er, output int lat);
    logic [2:0]  md;
    logic        ys, ind;
    logic [7:0]  ix;
    logic [15:0] base;
    md  = op[6:4];
    ys  = (pf == 8'h90) || (pf == 8'h91);
    ind = (pf == 8'h91) || (pf == 8'h92);
    ix  = ys ? y : x;
    er  = !op[7] || (md < 3'd2) || (ind && (md == 3'd2 || md == 3'd7))
        || (dst && md == 3'd2);
    im  = !er && (md == 3'd2);
    e   = 16'h0;
    lat = 1;
    base = 16'h0;
    if (!er && !im) begin
      if (ind) begin
        if (md == 3'd4 || md == 3'd5) begin
          base = {mb(a), mb(a + 8'd1)};
          lat  = 5;
        end else begin
          base = {8'h00, mb(a)};
          lat  = 3;
        end
      end else if (md == 3'd3 || md == 3'd6) base = {8'h00, a};
      else if (md == 3'd4 || md == 3'd5)    base = {a, b};
      e = base + ((md >= 3'd5) ? {8'h00, ix} : 16'h0);
    end
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [7:0] pf,
                                   input logic er, input logic im, input logic dst);
    if (er) return (dst && op[6:4] == 3'd2 && op[7]) ? "R6" : "R7";
    if (im) return "R6";
    if (pf == 8'h91) return "R5";
    if (pf == 8'h92) return "R4";
    if (pf == 8'h90) return "R3";
    if (op[6:4] >= 3'd5) return "R2";
    return "R1";
  endfunction

  task automatic run(input logic [7:0] op, input logic [7:0] pf,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] x,
      input logic [7:0] y, input logic dst, input logic poke, input string req);
    logic [15:0] e_exp, e_got;
    logic        im_exp, er_exp, im_got, er_got;
    int          lat_exp, got, ndone;
    model(op, pf, a, b, x, y, dst, e_exp, im_exp, er_exp, lat_exp);
    @(negedge clk);
    rd_cnt = 0;
    opc_upper = op[7:4]; prefix = pf; opnd_a = a; opnd_b = b;
    idx_x = x; idx_y = y; is_dest = dst; start = 1'b1;
    got = 0; ndone = 0; e_got = '0; im_got = 0; er_got = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (done) begin
        ndone++;
        if (got == 0) begin
          got = k; e_got = ea; im_got = ea_imm; er_got = ea_err;
        end
      end
      if (k == 1 && poke) begin
        opc_upper = 4'hB; prefix = 8'h00; opnd_a = ~a; idx_x = ~x;
        idx_y = ~y; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(req, "ea", {16'h0, e_got}, {16'h0, e_exp});
    chk(req, "imm", {31'h0, im_got}, {31'h0, im_exp});
    chk(req, "err", {31'h0, er_got}, {31'h0, er_exp});
    chk("R8", "latency", got, lat_exp);
    chk(poke ? "R10" : "R8", "done pulses", ndone, 1);
    chk(er_exp ? "R7" : "R9", "reads", rd_cnt,
        (lat_exp == 5) ? 2 : ((lat_exp == 3) ? 1 : 0));
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] op, pf, a, b, x, y;
    logic       dst, poke, imx, erx;
    logic [15:0] ex;
    int         lx;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk("R11", "done in reset", {31'h0, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "done after reset", {31'h0, done}, 0);
    chk("R11", "ea after reset", {16'h0, ea}, 0);
    chk("R11", "rd_en after reset", {31'h0, rd_en}, 0);
    chk("R11", "err after reset", {31'h0, ea_err}, 0);

    run(8'hB3, 8'h00, 8'h5C, 8'h77, 8'h10, 8'h20, 0, 0, "R1");
    run(8'hC0, 8'h00, 8'h12, 8'h34, 8'h10, 8'h20, 0, 0, "R1");
    run(8'hE0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h01, 0, 0, "R2");
    run(8'hD0, 8'h90, 8'hFF, 8'hF0, 8'h01, 8'h20, 0, 0, "R2");
    run(8'hF0, 8'h90, 8'h00, 8'h00, 8'h11, 8'h7E, 0, 0, "R3");
    run(8'hF0, 8'h00, 8'h00, 8'h00, 8'h11, 8'h7E, 0, 0, "R2");
    run(8'hB0, 8'h92, 8'h40, 8'h00, 8'h05, 8'h06, 0, 0, "R4");
    run(8'hC0, 8'h92, 8'hFF, 8'h00, 8'h05, 8'h06, 0, 0, "R4");
    run(8'hD0, 8'h92, 8'h33, 8'h00, 8'hC5, 8'h06, 0, 0, "R4");
    run(8'hE0, 8'h91, 8'h10, 8'h00, 8'h01, 8'hF0, 0, 0, "R5");
    run(8'hD0, 8'h91, 8'h20, 8'h00, 8'h01, 8'hFE, 1, 0, "R5");
    run(8'hA0, 8'h00, 8'h55, 8'h00, 8'h01, 8'h02, 0, 0, "R6");
    run(8'hA0, 8'h00, 8'h55, 8'h00, 8'h01, 8'h02, 1, 0, "R6");
    run(8'hA0, 8'h92, 8'h55, 8'h00, 8'h01, 8'h02, 0, 0, "R7");
    run(8'hF0, 8'h91, 8'h55, 8'h00, 8'h01, 8'h02, 0, 0, "R7");
    run(8'h30, 8'h00, 8'h55, 8'h00, 8'h01, 8'h02, 0, 0, "R7");
    run(8'h90, 8'h00, 8'h55, 8'h00, 8'h01, 8'h02, 0, 0, "R7");
    run(8'hC0, 8'h92, 8'h61, 8'h00, 8'h01, 8'h02, 0, 1, "R10");
    run(8'hE0, 8'h91, 8'h62, 8'h00, 8'h01, 8'h09, 0, 1, "R10");

    for (int i = 0; i < 400; i++) begin
      op = $urandom();
      if (($urandom() % 8) != 0) op[7] = 1'b1;
      case ($urandom() % 5)
        0: pf = 8'h00;
        1: pf = 8'h90;
        2: pf = 8'h91;
        3: pf = 8'h92;
        default: pf = $urandom();
      endcase
      a = $urandom(); b = $urandom(); x = $urandom(); y = $urandom();
      dst = (($urandom() % 4) == 0);
      model(op, pf, a, b, x, y, dst, ex, imx, erx, lx);
      poke = (lx > 1) && (($urandom() % 4) == 0);
      run(op, pf, a, b, x, y, dst, poke,
          poke ? "R10" : tag_of(op, pf, erx, imx, dst));
    end
    finish_up();
  end

endmodule